// File: doc/BRIEF.md
# Channel Power Integrator

The block sits after the channelizer of one polarization of one antenna and receives a spectrum of complex samples, one channel per valid cycle, channel 0 first. For every sample it forms the instantaneous power (real squared plus imaginary squared) and the square of that power. It adds both into two separate accumulators held for each channel. The power and the power-squared integrations are kept side by side so that a downstream stage can derive variance or kurtosis per channel. A board runs four instances in parallel, one per antenna/polarization stream.

An integration spans a programmable number of complete frames, with a nominal setting giving fifty results per second. When the last frame of an integration has been taken in, the block streams every channel out in ascending order, one word per cycle, with start and end markers and a per-channel sticky saturation flag. The first frame of the next integration writes its values over the stored ones instead of adding to them, so no clearing pass is needed and the readout overlaps the arrival of that frame. Channel storage is one inferred RAM of `NUM_CH` words, shared between accumulation and readout.

Two state machines control the block. The frame machine has the states SEEK and RUN. In SEEK, a valid sample with the sync bit high is taken as channel 0 and moves it to RUN. A valid sample without sync in SEEK is dropped. In RUN, every valid sample is taken. Taking the last channel moves it back to SEEK. The dump machine has the states IDLE and READ. The close of an integration moves it from IDLE to READ. In READ it steps through all channels. After the last channel it returns to IDLE, or it restarts at channel 0 when a new close arrives in that same cycle.

Top module: `chan_power_integrator`

## Requirements
- R1: For each channel, the dumped `dump_pwr` is the sum over the integration of re²+im², and `dump_sq` is the sum of (re²+im²)², with inputs read as two's-complement `IN_W`-bit values.
- R2: The first frame taken after reset or after an integration closes replaces each channel's stored sums, so nothing carries over from an earlier integration.
- R3: A sum that would exceed its width is held at all ones. `dump_ovf` is 1 for that channel in that dump and is 0 again for the next integration.
- R4: A frame is taken only if its first valid sample has `in_sync` = 1. Valid samples arriving in SEEK without sync are discarded and produce no output.
- R5: `in_sync` high on a sample in the middle of a taken frame has no effect; the frame is accumulated normally.
- R6: A dump starts after `integ_len` complete frames have been taken. The value 0 acts as 1, and no dump occurs before the count is reached.
- R7: A dump is `NUM_CH` consecutive cycles with `dump_valid` = 1. Channels run from 0 upward. `dump_sof` is high only with channel 0 and `dump_eof` is high only with channel `NUM_CH`-1.
- R8: The first frame of the next integration may arrive back-to-back with the close, during the readout, without altering any dumped value. With `integ_len` = 1 this holds for consecutive dumps.
- R9: During and right after reset, `dump_valid`, `dump_sof` and `dump_eof` are 0.
- R10: Cycles with `in_valid` = 0 are ignored, including gaps inside a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_sync | input | 1 | Marks channel 0 of a frame |
| in_re | input | IN_W | Real part, signed |
| in_im | input | IN_W | Imaginary part, signed |
| integ_len | input | INTEG_W | Frames per integration (0 acts as 1) |
| dump_valid | output | 1 | Dump word present |
| dump_sof | output | 1 | First word of a dump |
| dump_eof | output | 1 | Last word of a dump |
| dump_chan | output | clog2(NUM_CH) | Channel of the dump word |
| dump_pwr | output | PACC_W | Accumulated power |
| dump_sq | output | SACC_W | Accumulated power squared |
| dump_ovf | output | 1 | Saturation occurred in this channel |

## Verification
The dump readout and the first frame of the next integration can occupy the same cycles: readout reads channel c while the new frame overwrites channels below c. The bench provokes this by sending frames with no idle cycle between them, with an integration length of one and of two. It also makes the close of one integration fall on the last readout cycle of the previous one. A scoreboard model predicts every dump word. Any word read after being overwritten, or any restart that drops or repeats a channel, shows up as a value or channel mismatch.

// File: rtl/chpi_pkg.sv
package chpi_pkg;

    typedef enum logic {
        FR_SEEK = 1'b0,
        FR_RUN  = 1'b1
    } frame_state_t;

    typedef enum logic {
        DP_IDLE = 1'b0,
        DP_READ = 1'b1
    } dump_state_t;

endpackage

// File: rtl/chpi_power.sv
module chpi_power #(
    parameter int IN_W = 8,
    parameter int CH_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic [CH_W-1:0]     chan,
    input  logic                first,
    input  logic [IN_W-1:0]     re,
    input  logic [IN_W-1:0]     im,
    output logic                s1_valid,
    output logic [CH_W-1:0]     s1_chan,
    output logic                s1_first,
    output logic [2*IN_W-1:0]   s1_pwr,
    output logic [4*IN_W-1:0]   s1_sq
);
    localparam int PWR_W = 2 * IN_W;
    localparam int SQ_W  = 4 * IN_W;

    logic signed [PWR_W-1:0] re_x, im_x, re_sq, im_sq;
    logic [PWR_W-1:0]        pwr;
    logic [SQ_W-1:0]         pwr_x, sq;

    always_comb begin
        re_x  = {{IN_W{re[IN_W-1]}}, re};
        im_x  = {{IN_W{im[IN_W-1]}}, im};
        re_sq = re_x * re_x;
        im_sq = im_x * im_x;
        pwr   = $unsigned(re_sq) + $unsigned(im_sq);
        pwr_x = {{PWR_W{1'b0}}, pwr};
        sq    = pwr_x * pwr_x;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_chan  <= '0;
            s1_first <= 1'b0;
            s1_pwr   <= '0;
            s1_sq    <= '0;
        end else begin
            s1_valid <= take;
            if (take) begin
                s1_chan  <= chan;
                s1_first <= first;
                s1_pwr   <= pwr;
                s1_sq    <= sq;
            end
        end
    end

endmodule

// File: rtl/chpi_sat_add.sv
module chpi_sat_add #(
    parameter int ADD_W = 16,
    parameter int ACC_W = 32
) (
    input  logic             clear,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [ADD_W-1:0] add_in,
    output logic [ACC_W-1:0] sum,
    output logic             sat
);
    logic [ACC_W-1:0] add_x;
    logic [ACC_W:0]   wide;

    always_comb begin
        add_x = ACC_W'(add_in);
        wide  = {1'b0, acc_in} + {1'b0, add_x};
        if (clear) begin
            sum = add_x;
            sat = 1'b0;
        end else if (wide[ACC_W]) begin
            sum = '1;
            sat = 1'b1;
        end else begin
            sum = wide[ACC_W-1:0];
            sat = 1'b0;
        end
    end

endmodule

// File: rtl/chpi_chan_ram.sv
module chpi_chan_ram #(
    parameter int DEPTH = 4096,
    parameter int WIDTH = 97,
    parameter int AW    = 12
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/chpi_frame_fsm.sv
module chpi_frame_fsm
    import chpi_pkg::*;
#(
    parameter int NUM_CH  = 4096,
    parameter int CH_W    = 12,
    parameter int INTEG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sync,
    input  logic [INTEG_W-1:0] integ_len,
    output logic               take,
    output logic [CH_W-1:0]    cur_chan,
    output logic               first,
    output logic               close,
    output logic               seeking
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    frame_state_t       state_q, state_d;
    logic [CH_W-1:0]    ch_q;
    logic [INTEG_W-1:0] frm_q;
    logic [INTEG_W-1:0] eff_len;
    logic               frame_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_SEEK;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_SEEK: if (take)      state_d = FR_RUN;
            FR_RUN:  if (frame_end) state_d = FR_SEEK;
        endcase
    end

    always_comb begin
        seeking   = (state_q == FR_SEEK);
        take      = in_valid && (!seeking || in_sync);
        cur_chan  = seeking ? '0 : ch_q;
        frame_end = take && (cur_chan == LAST_CH);
        eff_len   = (integ_len == '0) ? INTEG_W'(1) : integ_len;
        first     = (frm_q == '0);
        close     = frame_end && (frm_q >= eff_len - INTEG_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q  <= '0;
            frm_q <= '0;
        end else begin
            if (take) begin
                ch_q <= frame_end ? '0 : cur_chan + CH_W'(1);
            end
            if (frame_end) begin
                frm_q <= close ? '0 : frm_q + INTEG_W'(1);
            end
        end
    end

    AST_RUN_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_RUN) |-> (ch_q != '0)); // R5

endmodule

// File: rtl/chpi_dump_fsm.sv
module chpi_dump_fsm
    import chpi_pkg::*;
#(
    parameter int NUM_CH = 4096,
    parameter int CH_W   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            rd_active,
    output logic [CH_W-1:0] rd_addr,
    output logic            dump_valid,
    output logic            dump_sof,
    output logic            dump_eof,
    output logic [CH_W-1:0] dump_chan
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    dump_state_t     state_q, state_d;
    logic [CH_W-1:0] cnt_q;
    logic            at_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        at_last = (cnt_q == LAST_CH);
        state_d = state_q;
        unique case (state_q)
            DP_IDLE: if (start)              state_d = DP_READ;
            DP_READ: if (at_last && !start)  state_d = DP_IDLE;
        endcase
    end

    always_comb begin
        rd_active = (state_q == DP_READ);
        rd_addr   = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            dump_valid <= 1'b0;
            dump_sof   <= 1'b0;
            dump_eof   <= 1'b0;
            dump_chan  <= '0;
        end else begin
            if (start && (!rd_active || at_last)) begin
                cnt_q <= '0;
            end else if (rd_active) begin
                cnt_q <= at_last ? '0 : cnt_q + CH_W'(1);
            end
            dump_valid <= rd_active;
            dump_sof   <= rd_active && (cnt_q == '0);
            dump_eof   <= rd_active && at_last;
            dump_chan  <= rd_active ? cnt_q : '0;
        end
    end

    AST_RESTART_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (start && rd_active) |-> at_last); // R8

    AST_DUMP_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (dump_valid && !dump_eof) |=> (dump_valid && dump_chan == $past(dump_chan) + CH_W'(1))); // R7

    AST_SOF_CHAN0: assert property (@(posedge clk) disable iff (!rst_n)
        (dump_valid && dump_sof) |-> (dump_chan == '0)); // R7

endmodule

// File: rtl/chan_power_integrator.sv
module chan_power_integrator #(
    parameter int NUM_CH  = 4096,
    parameter int IN_W    = 8,
    parameter int PACC_W  = 32,
    parameter int SACC_W  = 64,
    parameter int INTEG_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_sync,
    input  logic [IN_W-1:0]            in_re,
    input  logic [IN_W-1:0]            in_im,
    input  logic [INTEG_W-1:0]         integ_len,
    output logic                       dump_valid,
    output logic                       dump_sof,
    output logic                       dump_eof,
    output logic [$clog2(NUM_CH)-1:0]  dump_chan,
    output logic [PACC_W-1:0]          dump_pwr,
    output logic [SACC_W-1:0]          dump_sq,
    output logic                       dump_ovf
);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int PWR_W  = 2 * IN_W;
    localparam int SQ_W   = 4 * IN_W;
    localparam int WORD_W = 1 + SACC_W + PACC_W;

    logic              take, first, close, seeking;
    logic [CH_W-1:0]   cur_chan;
    logic              s1_valid, s1_first;
    logic [CH_W-1:0]   s1_chan;
    logic [PWR_W-1:0]  s1_pwr;
    logic [SQ_W-1:0]   s1_sq;
    logic              rd_active;
    logic [CH_W-1:0]   rd_addr, raddr;
    logic [WORD_W-1:0] rdata, wdata;
    logic [PACC_W-1:0] old_pwr, new_pwr;
    logic [SACC_W-1:0] old_sq, new_sq;
    logic              old_ovf, pwr_sat, sq_sat, new_ovf;

    chpi_frame_fsm #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .INTEG_W(INTEG_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sync  (in_sync),
        .integ_len(integ_len),
        .take     (take),
        .cur_chan (cur_chan),
        .first    (first),
        .close    (close),
        .seeking  (seeking)
    );

    chpi_power #(
        .IN_W(IN_W),
        .CH_W(CH_W)
    ) u_power (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .chan    (cur_chan),
        .first   (first),
        .re      (in_re),
        .im      (in_im),
        .s1_valid(s1_valid),
        .s1_chan (s1_chan),
        .s1_first(s1_first),
        .s1_pwr  (s1_pwr),
        .s1_sq   (s1_sq)
    );

    chpi_dump_fsm #(
        .NUM_CH(NUM_CH),
        .CH_W  (CH_W)
    ) u_dump (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (take && close),
        .rd_active (rd_active),
        .rd_addr   (rd_addr),
        .dump_valid(dump_valid),
        .dump_sof  (dump_sof),
        .dump_eof  (dump_eof),
        .dump_chan (dump_chan)
    );

    // Readout owns the read port while active; only overwrite frames arrive then.
    assign raddr = rd_active ? rd_addr : cur_chan;

    chpi_chan_ram #(
        .DEPTH(NUM_CH),
        .WIDTH(WORD_W),
        .AW   (CH_W)
    ) u_ram (
        .clk  (clk),
        .we   (s1_valid),
        .waddr(s1_chan),
        .wdata(wdata),
        .raddr(raddr),
        .rdata(rdata)
    );

    assign {old_ovf, old_sq, old_pwr} = rdata;

    chpi_sat_add #(
        .ADD_W(PWR_W),
        .ACC_W(PACC_W)
    ) u_add_pwr (
        .clear (s1_first),
        .acc_in(old_pwr),
        .add_in(s1_pwr),
        .sum   (new_pwr),
        .sat   (pwr_sat)
    );

    chpi_sat_add #(
        .ADD_W(SQ_W),
        .ACC_W(SACC_W)
    ) u_add_sq (
        .clear (s1_first),
        .acc_in(old_sq),
        .add_in(s1_sq),
        .sum   (new_sq),
        .sat   (sq_sat)
    );

    always_comb begin
        new_ovf = (!s1_first && old_ovf) || pwr_sat || sq_sat;
        wdata   = {new_ovf, new_sq, new_pwr};
    end

    always_comb begin
        dump_pwr = dump_valid ? old_pwr : '0;
        dump_sq  = dump_valid ? old_sq  : '0;
        dump_ovf = dump_valid && old_ovf;
    end

    AST_SEEK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (seeking && in_valid && !in_sync) |=> !s1_valid); // R4

    AST_DUMP_NO_RMW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && take) |-> first); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dump_valid && dump_ovf) |-> (dump_pwr == '1 || dump_sq == '1)); // R3

endmodule

// File: tb/chan_power_integrator_test.sv
`timescale 1ns/1ps
module chan_power_integrator_test;
    localparam int N  = 8;
    localparam int IW = 8;
    localparam int PA = 18;
    localparam int SA = 33;
    localparam int LW = 4;
    localparam int CW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sync = 1'b0;
    logic [IW-1:0] in_re = '0;
    logic [IW-1:0] in_im = '0;
    logic [LW-1:0] integ_len = '0;
    logic          dump_valid, dump_sof, dump_eof, dump_ovf;
    logic [CW-1:0] dump_chan;
    logic [PA-1:0] dump_pwr;
    logic [SA-1:0] dump_sq;

    always #2.5 clk = ~clk;

    chan_power_integrator #(
        .NUM_CH(N), .IN_W(IW), .PACC_W(PA), .SACC_W(SA), .INTEG_W(LW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
        .in_re(in_re), .in_im(in_im), .integ_len(integ_len),
        .dump_valid(dump_valid), .dump_sof(dump_sof), .dump_eof(dump_eof),
        .dump_chan(dump_chan), .dump_pwr(dump_pwr), .dump_sq(dump_sq),
        .dump_ovf(dump_ovf)
    );

    typedef struct {
        int     ch;
        longint p;
        longint s;
        bit     o;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    int     checks = 0;
    int     fails = 0;
    int     seen = 0;
    longint mp[N];
    longint ms[N];
    bit     mo[N];
    int     fcount = 0;
    int     ilen = 0;
    bit     prev_mid = 1'b0;

    localparam longint PMAX = (longint'(1) << PA) - 1;
    localparam longint SMAX = (longint'(1) << SA) - 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int vre(input int ch, input int f, input int mode);
        if (mode == 1 && ch % 2 == 0) return -128;
        return ((ch * 37 + f * 11 + 5) % 256) - 128;
    endfunction

    function automatic int vim(input int ch, input int f, input int mode);
        if (mode == 1 && ch % 2 == 0) return -128;
        return ((ch * 53 + f * 29 + 17) % 256) - 128;
    endfunction

    task automatic step(input bit v, input bit s, input int re, input int im);
        @(posedge clk);
        #1;
        in_valid = v;
        in_sync  = s;
        in_re    = IW'(re);
        in_im    = IW'(im);
    endtask

    task automatic model_frame(input int f, input int mode, input string tag);
        int eff;
        for (int ch = 0; ch < N; ch++) begin
            longint re = vre(ch, f, mode);
            longint im = vim(ch, f, mode);
            longint p  = re * re + im * im;
            longint s  = p * p;
            if (fcount == 0) begin
                mp[ch] = p; ms[ch] = s; mo[ch] = 1'b0;
            end else begin
                mp[ch] = mp[ch] + p;
                ms[ch] = ms[ch] + s;
                if (mp[ch] > PMAX) begin mp[ch] = PMAX; mo[ch] = 1'b1; end
                if (ms[ch] > SMAX) begin ms[ch] = SMAX; mo[ch] = 1'b1; end
            end
        end
        fcount++;
        eff = (ilen == 0) ? 1 : ilen;
        if (fcount >= eff) begin
            for (int ch = 0; ch < N; ch++) begin
                exp_t e;
                e.ch = ch; e.p = mp[ch]; e.s = ms[ch]; e.o = mo[ch]; e.tag = tag;
                sb.push_back(e);
            end
            fcount = 0;
        end
    endtask

    task automatic send_frame(input int f, input int mode, input bit sync_ok,
                              input bit gaps, input bit mid_sync,
                              input bit idle_after, input string tag);
        if (sync_ok) model_frame(f, mode, tag);
        for (int ch = 0; ch < N; ch++) begin
            step(1'b1, (ch == 0 && sync_ok) || (mid_sync && ch == 3),
                 vre(ch, f, mode), vim(ch, f, mode));
            if (gaps && ch % 3 == 1) step(1'b0, 1'b0, 0, 0);
        end
        if (idle_after) step(1'b0, 1'b0, 0, 0);
    endtask

    task automatic set_len(input int l);
        @(posedge clk);
        #1;
        integ_len = LW'(l);
        ilen = l;
    endtask

    task automatic drain();
        wait (sb.size() == 0);
        repeat (6) @(posedge clk);
    endtask

    // Monitor: pops the scoreboard as dump words appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_mid) check(dump_valid, "R7", "dump_valid gap", longint'(dump_valid), 1);
            if (dump_valid) begin
                seen++;
                if (sb.size() == 0) begin
                    check(1'b0, "R6", "unexpected dump word chan", longint'(dump_chan), -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(dump_chan == CW'(e.ch) && dump_sof == (e.ch == 0) &&
                          dump_eof == (e.ch == N - 1), "R7", "dump channel",
                          longint'(dump_chan), e.ch);
                    check(longint'(dump_pwr) == e.p, e.tag, "dump_pwr", longint'(dump_pwr), e.p);
                    check(longint'(dump_sq) == e.s, e.tag, "dump_sq", longint'(dump_sq), e.s);
                    check(dump_ovf == e.o, e.tag, "dump_ovf", longint'(dump_ovf), longint'(e.o));
                end
            end
            prev_mid = dump_valid && !dump_eof;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int s0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!dump_valid && !dump_sof && !dump_eof, "R9", "outputs in reset",
              longint'({dump_valid, dump_sof, dump_eof}), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!dump_valid, "R9", "dump_valid after reset", longint'(dump_valid), 0);

        // R1: single-frame integration
        set_len(1);
        send_frame(0, 0, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
        drain();

        // R10: three frames with idle gaps inside them
        set_len(3);
        for (int f = 1; f <= 3; f++) send_frame(f, 0, 1'b1, 1'b1, 1'b0, 1'b1, "R10");
        drain();

        // R2: new integration must not carry the previous sums
        set_len(2);
        send_frame(4, 0, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
        send_frame(5, 0, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
        drain();

        // R4: frame without sync is discarded entirely
        set_len(1);
        s0 = seen;
        send_frame(6, 0, 1'b0, 1'b0, 1'b0, 1'b1, "R4");
        repeat (N + 6) @(posedge clk);
        check(seen == s0, "R4", "dump words after unsynced frame", seen - s0, 0);
        send_frame(7, 0, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
        drain();

        // R5: sync inside a taken frame
        send_frame(8, 0, 1'b1, 1'b0, 1'b1, 1'b1, "R5");
        drain();

        // R6: zero acts as one, and no early dump with length two
        set_len(0);
        send_frame(9, 0, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
        drain();
        set_len(2);
        s0 = seen;
        send_frame(10, 0, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
        repeat (N + 6) @(posedge clk);
        check(seen == s0, "R6", "dump before count reached", seen - s0, 0);
        send_frame(11, 0, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
        drain();

        // R8: readout overlapping back-to-back frames
        set_len(1);
        send_frame(12, 0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        send_frame(13, 0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        send_frame(14, 0, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        drain();
        set_len(2);
        for (int f = 15; f <= 18; f++) send_frame(f, 0, 1'b1, 1'b0, 1'b0, f == 18, "R8");
        drain();

        // R3: saturation on even channels, then flag clears
        set_len(8);
        for (int f = 19; f <= 26; f++) send_frame(f, 1, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
        drain();
        set_len(1);
        send_frame(27, 0, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
        drain();

        check(sb.size() == 0, "R7", "words left in scoreboard", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule